// File: doc/BRIEF.md
# Lowest-Bit Manipulation ALU

This block is a registered one-stage bit-manipulation unit for a W-bit datapath. Each cycle in which `in_valid` is high, it takes an operand `in_x`, a second operand `in_y` and a 4-bit opcode. One cycle later it presents the result on `out_result`, raises `out_valid`, and sets `out_zero` when that result is all zeros.

Most opcodes work on the least significant set bit or the least significant clear bit of `in_x`. They isolate it, clear or set it, or build masks that reach up to it. Every one of these is formed from a single shared adder, which computes either x+1 or x−1, combined with x or ~x through an AND, OR or XOR. Three further opcodes do not use the adder: and-not, bit-field extract, and clearing of the high bits from a given index. The adder wraps modulo 2^W.

The block sits in an execution pipeline behind the instruction decoder. The decoder supplies the opcode and the operands, and the unit writes back one result per accepted operation.

Top module: `blm_alu`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. Reset (active-low `rst_n`) drives `out_valid`, `out_result` and `out_zero` to 0.
- R2: While `in_valid` is low, `out_result` and `out_zero` keep their values.
- R3: Opcode 0 returns (~x) & y.
- R4: Opcode 1 returns x & (0−x), which isolates the lowest set bit. Opcode 2 returns x & (x−1), which clears it. Opcode 3 returns x ^ (x−1).
- R5: Opcode 4 returns x & (x+1), which clears the trailing ones. Opcode 5 returns x | (x−1), which sets the trailing zeros.
- R6: Opcode 6 returns x | ~(x+1). Opcode 7 returns ~x & (x+1). Opcode 8 returns x ^ (x+1). Opcode 9 returns x | (x+1).
- R7: Opcode 10 returns ~x | (x−1). Opcode 11 returns ~x | (x+1). Opcode 12 returns ~x & (x−1).
- R8: Opcode 13 returns (x >> s) & ((1 << n) − 1), where s = y[7:0] and n = y[15:8]. If s ≥ W the result is 0. If n ≥ W, all bits of the shifted value are kept.
- R9: Opcode 14 clears every bit of x at position y[7:0] or above. If y[7:0] ≥ W, x is returned unchanged.
- R10: Arithmetic wraps modulo 2^W. Opcode 1 applied to x = 0 returns 0, and x+1 of all-ones is taken as 0.
- R11: `out_zero` is high exactly when `out_result` is 0 for the operation just completed.
- R12: Opcode 15 is reserved and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 4 | Opcode (see R3 to R12) |
| in_x | input | W | First operand |
| in_y | input | W | Second operand; it also carries the field controls for opcodes 13 and 14 |
| out_valid | output | 1 | Result valid |
| out_result | output | W | Registered result |
| out_zero | output | 1 | Result-is-zero flag |

## Verification
The bench builds the block with W = 16. At that width, the 8-bit start, length and index fields can be set to W and beyond, so the out-of-range paths of extract and zero-high are exercised. The all-ones operand 16'hFFFF reaches the wrap of the incrementing opcodes. Small hand-checked operands such as 16'h0057 and 16'h0050 give distinct trailing-one and trailing-zero runs, so each combining operation is visible in the result.

// File: rtl/blm_pkg.sv
package blm_pkg;

    typedef enum logic [3:0] {
        OP_ANDN        = 4'd0,
        OP_LSB_ISO     = 4'd1,
        OP_LSB_CLR     = 4'd2,
        OP_LSB_MSK     = 4'd3,
        OP_CLR_TONES   = 4'd4,
        OP_SET_TZEROS  = 4'd5,
        OP_LCB_ISO_INV = 4'd6,
        OP_LCB_ISO     = 4'd7,
        OP_LCB_MSK     = 4'd8,
        OP_LCB_SET     = 4'd9,
        OP_LSB_ISO_INV = 4'd10,
        OP_TONES_INV   = 4'd11,
        OP_TZ_MSK      = 4'd12,
        OP_FIELD_EXT   = 4'd13,
        OP_ZERO_HIGH   = 4'd14,
        OP_RESERVED    = 4'd15
    } blm_op_e;

    // Selects the decrement direction of the shared adder.
    function automatic logic op_uses_dec(blm_op_e op);
        unique case (op)
            OP_LSB_ISO, OP_LSB_CLR, OP_LSB_MSK,
            OP_SET_TZEROS, OP_LSB_ISO_INV, OP_TZ_MSK: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/blm_incdec.sv
module blm_incdec #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic         dec,
    output logic [W-1:0] sum
);
    // One adder: x + 1 or x + all-ones (that is, x - 1), modulo 2^W.
    logic [W-1:0] addend;

    always_comb begin
        addend = dec ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
        sum    = x + addend;
    end
endmodule

// File: rtl/blm_field.sv
module blm_field #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [7:0]   start,
    input  logic [7:0]   len,
    input  logic [7:0]   index,
    output logic [W-1:0] extract,
    output logic [W-1:0] zero_high
);
    logic [W-1:0] shifted;
    logic [W-1:0] len_mask;
    logic [W-1:0] idx_mask;

    // Shift with an out-of-range guard.
    always_comb begin
        if (int'(start) >= W) shifted = '0;
        else                  shifted = x >> start;
    end

    // Per-bit masks: a bit survives when its position is below the limit.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign len_mask[i] = (int'(len)   > i);
        assign idx_mask[i] = (int'(index) > i);
    end

    assign extract   = shifted & len_mask;
    assign zero_high = x & idx_mask;
endmodule

// File: rtl/blm_combine.sv
module blm_combine #(
    parameter int W = 32
) (
    input  blm_pkg::blm_op_e op,
    input  logic [W-1:0]     x,
    input  logic [W-1:0]     y,
    input  logic [W-1:0]     sum,
    input  logic [W-1:0]     extract,
    input  logic [W-1:0]     zero_high,
    output logic [W-1:0]     res
);
    import blm_pkg::*;

    always_comb begin
        unique case (op)
            OP_ANDN:        res = ~x & y;
            OP_LSB_ISO:     res = x & ~sum;     // -x == ~(x - 1)
            OP_LSB_CLR:     res = x & sum;
            OP_LSB_MSK:     res = x ^ sum;
            OP_CLR_TONES:   res = x & sum;
            OP_SET_TZEROS:  res = x | sum;
            OP_LCB_ISO_INV: res = x | ~sum;
            OP_LCB_ISO:     res = ~x & sum;
            OP_LCB_MSK:     res = x ^ sum;
            OP_LCB_SET:     res = x | sum;
            OP_LSB_ISO_INV: res = ~x | sum;
            OP_TONES_INV:   res = ~x | sum;
            OP_TZ_MSK:      res = ~x & sum;
            OP_FIELD_EXT:   res = extract;
            OP_ZERO_HIGH:   res = zero_high;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/blm_alu.sv
module blm_alu #(
    parameter int W = 32   // must be at least 16: y[15:8] carries the field length
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_zero
);
    import blm_pkg::*;

    blm_op_e      op;
    logic [W-1:0] sum;
    logic [W-1:0] extract;
    logic [W-1:0] zero_high;
    logic [W-1:0] res;

    assign op = blm_op_e'(in_op);

    blm_incdec #(.W(W)) u_incdec (
        .x   (in_x),
        .dec (op_uses_dec(op)),
        .sum (sum)
    );

    blm_field #(.W(W)) u_field (
        .x         (in_x),
        .start     (in_y[7:0]),
        .len       (in_y[15:8]),
        .index     (in_y[7:0]),
        .extract   (extract),
        .zero_high (zero_high)
    );

    blm_combine #(.W(W)) u_combine (
        .op        (op),
        .x         (in_x),
        .y         (in_y),
        .sum       (sum),
        .extract   (extract),
        .zero_high (zero_high),
        .res       (res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zero   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res;
                out_zero   <= (res == '0);
            end
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_zero)));
    p_iso_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LSB_ISO) |=> $onehot0(out_result));
    p_clr_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LSB_CLR && in_x != '0) |=>
        ($countones(out_result) + 1 == $countones($past(in_x))));
    p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_result == '0)));
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_RESERVED) |=> (out_result == '0));
endmodule

// File: tb/blm_alu_bench.sv
`timescale 1ns/1ps
module blm_alu_bench;
    localparam int W = 16;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [W-1:0] in_x = '0;
    logic [W-1:0] in_y = '0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic         out_zero;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    blm_alu #(.W(W)) u_blm_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
        .out_result(out_result), .out_zero(out_zero)
    );

    // {op, x, y, expected}
    localparam logic [51:0] VEC [NV] = '{
        {4'd0,  16'h00FF, 16'h0F0F, 16'h0F00},  // R3
        {4'd1,  16'h0068, 16'h0000, 16'h0008},  // R4
        {4'd2,  16'h0068, 16'h0000, 16'h0060},  // R4
        {4'd3,  16'h0068, 16'h0000, 16'h000F},  // R4
        {4'd4,  16'h0057, 16'h0000, 16'h0050},  // R5
        {4'd5,  16'h0050, 16'h0000, 16'h005F},  // R5
        {4'd6,  16'h0057, 16'h0000, 16'hFFF7},  // R6
        {4'd7,  16'h0057, 16'h0000, 16'h0008},  // R6
        {4'd8,  16'h0057, 16'h0000, 16'h000F},  // R6
        {4'd9,  16'h0057, 16'h0000, 16'h005F},  // R6
        {4'd10, 16'h0050, 16'h0000, 16'hFFEF},  // R7
        {4'd11, 16'h0057, 16'h0000, 16'hFFF8},  // R7
        {4'd12, 16'h0050, 16'h0000, 16'h000F},  // R7
        {4'd13, 16'hABCD, 16'h0804, 16'h00BC},  // R8
        {4'd14, 16'hABCD, 16'h0006, 16'h000D},  // R9
        {4'd15, 16'hABCD, 16'h1234, 16'h0000}   // R12
    };

    task automatic check(input string req, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, got, exp);
        end
    endtask

    // Drive one operation; return after the result register has loaded.
    task automatic run(input logic [3:0] op, input logic [W-1:0] x,
                       input logic [W-1:0] y);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_x = x; in_y = y;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string req, input logic [3:0] op,
                             input logic [W-1:0] x, input logic [W-1:0] y,
                             input logic [W-1:0] exp);
        run(op, x, y);
        check(req, out_result, exp);
        check_bit({req, " R11 zero"}, out_zero, exp == '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1 reset valid", out_valid, 1'b0);
        check("R1 reset result", out_result, '0);
        check_bit("R1 reset zero", out_zero, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_check("R3-to-R12 table", VEC[i][51:48], VEC[i][47:32],
                      VEC[i][31:16], VEC[i][15:0]);
        end

        // R1: valid timing
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'd0; in_x = 16'h0000; in_y = 16'h00F0;
        @(negedge clk);
        check_bit("R1 valid after accept", out_valid, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R1 valid drops", out_valid, 1'b0);

        // R2: hold while idle
        in_op = 4'd15; in_x = 16'h1111; in_y = 16'h2222;
        repeat (2) @(negedge clk);
        check("R2 hold result", out_result, 16'h00F0);
        check_bit("R2 hold zero", out_zero, 1'b0);

        // R10: wrap cases
        run_check("R10 iso of zero", 4'd1, 16'h0000, 16'h0, 16'h0000);
        run_check("R10 set lcb of ones", 4'd9, 16'hFFFF, 16'h0, 16'hFFFF);
        run_check("R10 lcb mask of ones", 4'd8, 16'hFFFF, 16'h0, 16'hFFFF);
        run_check("R10 clear trailing ones of ones", 4'd4, 16'hFFFF, 16'h0, 16'h0000);
        run_check("R10 clr lsb of zero", 4'd2, 16'h0000, 16'h0, 16'h0000);
        run_check("R10 lsb mask of zero", 4'd3, 16'h0000, 16'h0, 16'hFFFF);

        // R8: extract bounds
        run_check("R8 start at W", 4'd13, 16'hABCD, 16'h0810, 16'h0000);
        run_check("R8 full length", 4'd13, 16'hABCD, 16'h1000, 16'hABCD);
        run_check("R8 length beyond W", 4'd13, 16'hABCD, 16'h1404, 16'h0ABC);
        run_check("R8 zero length", 4'd13, 16'hABCD, 16'h0003, 16'h0000);

        // R9: zero-high bounds
        run_check("R9 index at W", 4'd14, 16'hABCD, 16'h0010, 16'hABCD);
        run_check("R9 index big", 4'd14, 16'hABCD, 16'h00FF, 16'hABCD);
        run_check("R9 index zero", 4'd14, 16'hABCD, 16'h0000, 16'h0000);
        run_check("R9 index 15", 4'd14, 16'hABCD, 16'h000F, 16'h2BCD);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule